// File: doc/BRIEF.md
# Boot Flash Write Guard and Device Select

This block sits on a small host register bus. It produces one write-permission signal for each of two boot SPI flashes, a default device and a recovery device. It also produces one select line that names the flash the platform boots from. Each flash's write permission starts from a board switch. The switch value is taken while platform reset is held and is frozen when reset lets go. After that, only the host changes it: writing the unlock byte 0xC3 to a flash's register opens that flash for writing, and writing any other byte closes it again.

The boot device comes from one of two places. When the manual-enable switch is off, the management controller's select line decides. When it is on, the manual select switch decides. In both cases a 0 picks the default flash and a 1 picks the recovery flash. The host can read all four select-related inputs from a status register. Every switch and select input passes through a two-stage synchronizer before the block uses it. The SPI controller, the bus protocol engine and switch debouncing are outside this block.

Top module: `boot_flash_guard`

## Requirements
- R1: Each switch and select input reaches the logic through two flip-flops. A change set up before rising edge E shows on boot_sel_o and host_rdata_o after edge E+1 and not after edge E. A change on sw_wp_i reaches flash_wen_o during reset one edge later still.
- R2: While rst_n is low, flash_wen_o[i] loads the synchronized sw_wp_i[i] on every edge. After release it keeps the last loaded value, whatever the switches do afterwards.
- R3: A write strobe with address 0x41 and data 0xC3 sets flash_wen_o[0] to 1 from the edge that samples the strobe.
- R4: A write strobe to address 0x41 with any data other than 0xC3 clears flash_wen_o[0] to 0 from the edge that samples it.
- R5: Address 0x42 controls flash_wen_o[1] under the same unlock rule. A write to either of the two addresses leaves the other flash's bit unchanged.
- R6: Write strobes made while rst_n is low change nothing. During reset, flash_wen_o keeps following the switches.
- R7: boot_sel_o equals the synchronized mc_sel_i when sw_man_en_i is 0, and the synchronized sw_man_sel_i when sw_man_en_i is 1. On boot_sel_o, 0 means the default flash and 1 means the recovery flash.
- R8: host_rdata_o returns the status byte when host_addr_i is 0x40: bit 4 is sw_pkg_i, bit 5 is sw_man_en_i, bit 6 is sw_man_sel_i, bit 7 is mc_sel_i, and bits 3:0 are 0. Every other address, including 0x41 and 0x42, reads 0x00.
- R9: Write strobes to any address other than 0x41 and 0x42, including 0x40, leave flash_wen_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Platform reset, active low, synchronous |
| sw_wp_i | input | NUM_FLASH | Switch write-permission defaults; bit 0 is the default flash, bit 1 the recovery flash |
| sw_pkg_i | input | 1 | Boot package-type switch, for status only |
| sw_man_en_i | input | 1 | Manual boot-select enable switch |
| sw_man_sel_i | input | 1 | Manual boot-select switch |
| mc_sel_i | input | 1 | Management controller boot-select line |
| host_wr_i | input | 1 | Single-cycle host write strobe |
| host_addr_i | input | ADDR_W | Host register offset |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Combinational read data for host_addr_i |
| flash_wen_o | output | NUM_FLASH | Write permission per flash, 1 means writes allowed |
| boot_sel_o | output | 1 | Active boot flash, 0 default, 1 recovery |

## Verification
A host write affects flash_wen_o one edge after the strobe is sampled, so the bench raises the strobe at a falling edge and checks at the next falling edge. Select and status inputs take two edges to come through. The bench checks once after one edge, expecting the old value, and again after two, expecting the new one. Switch defaults need a third edge to land in the permission register during reset, and the bench samples at that point. Read data is combinational from the address, so each read is checked a fraction of a period after the address changes, away from any edge.

// File: rtl/bfg_pkg.sv
// Shared constants and types for the boot flash write guard.
// Assumes an 8-bit status byte layout; the field positions below are decoded by host software.
package bfg_pkg;

    // Boot device encoding on the select line.
    typedef enum logic {
        BOOT_DEFAULT  = 1'b0,
        BOOT_RECOVERY = 1'b1
    } boot_dev_e;

    // Synchronized select-related switch and controller inputs.
    typedef struct packed {
        logic mc_sel;
        logic man_sel;
        logic man_en;
        logic pkg;
    } sel_in_t;

    // Status byte field positions.
    localparam int STAT_PKG_BIT     = 4;
    localparam int STAT_MAN_EN_BIT  = 5;
    localparam int STAT_MAN_SEL_BIT = 6;
    localparam int STAT_MC_SEL_BIT  = 7;
    localparam int SEL_IN_W         = $bits(sel_in_t);

endpackage

// File: rtl/bfg_sync.sv
// Two-stage synchronizer for a bus of independent slow inputs (switches, select lines).
// Assumes each bit is quasi-static, so bits may be resynchronized independently.
// The stages carry no reset, so switch values are already valid while reset is held.
module bfg_sync #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the asynchronous inputs through two flops.
    always_ff @(posedge clk) begin
        stage1_q <= din;
        stage2_q <= stage1_q;
    end

    assign dout = stage2_q;

    // Output equals the input from two edges earlier.
    assert_two_stage_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/bfg_wen_reg.sv
// Write-permission register for one boot flash.
// During reset it loads its synchronized switch default on every edge.
// After reset, a host write to OFFSET sets it to 1 when the data equals KEY and clears it to 0 otherwise.
// Assumes host_wr is a single-cycle strobe, synchronous to clk.
module bfg_wen_reg #(
    parameter int                 ADDR_W = 8,
    parameter int                 DATA_W = 8,
    parameter logic [ADDR_W-1:0]  OFFSET = '0,
    parameter logic [DATA_W-1:0]  KEY    = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_def_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wen_o
);

    logic wen_q;
    logic hit;
    logic key_ok;

    // Decode a write aimed at this register and compare its data against the unlock key.
    always_comb begin
        hit    = wr_i && (addr_i == OFFSET);
        key_ok = (data_i == KEY);
    end

    // Follow the switch during reset; afterwards only a host write changes the state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q <= sw_def_i;
        end else if (hit) begin
            wen_q <= key_ok;
        end
    end

    assign wen_o = wen_q;

    // The unlock key opens the flash on the next edge.
    assert_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFFSET && data_i == KEY) |=> wen_o);

    // Any other data closes it.
    assert_relock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFFSET && data_i != KEY) |=> !wen_o);

    // Without a write to this offset, the state holds after reset.
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == OFFSET) |=> $stable(wen_o));

endmodule

// File: rtl/bfg_select.sv
// Picks the boot device from the manual switch or the management controller line.
// Also returns the host read data: the status byte at STATUS_OFS and zero everywhere else.
// Assumes DATA_W is at least 8 and that all inputs are already synchronized.
module bfg_select
    import bfg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFS = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  sel_in_t           sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              boot_sel_o
);

    boot_dev_e dev;

    // Choose the boot device source according to the manual-enable switch.
    always_comb begin
        if (sel_i.man_en) begin
            dev = boot_dev_e'(sel_i.man_sel);
        end else begin
            dev = boot_dev_e'(sel_i.mc_sel);
        end
        boot_sel_o = (dev == BOOT_RECOVERY);
    end

    // Assemble read data; every address except the status offset reads zero.
    always_comb begin
        rdata_o = '0;
        if (addr_i == STATUS_OFS) begin
            rdata_o[STAT_PKG_BIT]     = sel_i.pkg;
            rdata_o[STAT_MAN_EN_BIT]  = sel_i.man_en;
            rdata_o[STAT_MAN_SEL_BIT] = sel_i.man_sel;
            rdata_o[STAT_MC_SEL_BIT]  = sel_i.mc_sel;
        end
    end

    // The select output agrees with the source that the status byte shows.
    assert_mux_agrees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == STATUS_OFS) |->
        (boot_sel_o == (rdata_o[STAT_MAN_EN_BIT] ? rdata_o[STAT_MAN_SEL_BIT]
                                                 : rdata_o[STAT_MC_SEL_BIT])));

    // The low status bits are padding and read as zero.
    assert_status_pad_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == STATUS_OFS) |-> (rdata_o[3:0] == 4'h0));

endmodule

// File: rtl/boot_flash_guard.sv
// Top level of the boot flash write guard.
// Synchronizes the board inputs, holds one write-permission register per flash,
// and drives the boot device select and the host read data.
// Assumes the host bus gives a single-cycle write strobe and a combinational read.
module boot_flash_guard
    import bfg_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter int                NUM_FLASH  = 2,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h40,
    parameter logic [ADDR_W-1:0] WEN_BASE   = 8'h41,
    parameter logic [DATA_W-1:0] UNLOCK_KEY = 8'hC3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLASH-1:0] sw_wp_i,
    input  logic                 sw_pkg_i,
    input  logic                 sw_man_en_i,
    input  logic                 sw_man_sel_i,
    input  logic                 mc_sel_i,
    input  logic                 host_wr_i,
    input  logic [ADDR_W-1:0]    host_addr_i,
    input  logic [DATA_W-1:0]    host_wdata_i,
    output logic [DATA_W-1:0]    host_rdata_o,
    output logic [NUM_FLASH-1:0] flash_wen_o,
    output logic                 boot_sel_o
);

    localparam int SYNC_W = NUM_FLASH + SEL_IN_W;

    logic [SYNC_W-1:0]    raw_in;
    logic [SYNC_W-1:0]    sync_in;
    logic [NUM_FLASH-1:0] sw_wp_s;
    sel_in_t              sel_s;

    // Gather every slow input into one bus for synchronization.
    always_comb begin
        raw_in = {mc_sel_i, sw_man_sel_i, sw_man_en_i, sw_pkg_i, sw_wp_i};
    end

    bfg_sync #(
        .WIDTH (SYNC_W)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_in),
        .dout  (sync_in)
    );

    // Split the synchronized bus back into its fields.
    always_comb begin
        sw_wp_s = sync_in[NUM_FLASH-1:0];
        sel_s   = sel_in_t'(sync_in[SYNC_W-1:NUM_FLASH]);
    end

    // One write-permission register per flash, at consecutive offsets.
    for (genvar gi = 0; gi < NUM_FLASH; gi++) begin : g_wen
        bfg_wen_reg #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .OFFSET (WEN_BASE + ADDR_W'(gi)),
            .KEY    (UNLOCK_KEY)
        ) u_wen (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_def_i (sw_wp_s[gi]),
            .wr_i     (host_wr_i),
            .addr_i   (host_addr_i),
            .data_i   (host_wdata_i),
            .wen_o    (flash_wen_o[gi])
        );
    end

    bfg_select #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .STATUS_OFS (STATUS_OFS)
    ) u_select (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_s),
        .addr_i     (host_addr_i),
        .rdata_o    (host_rdata_o),
        .boot_sel_o (boot_sel_o)
    );

    // A write to the status or any unmapped offset leaves every permission bit unchanged.
    assert_foreign_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_i && (host_addr_i < WEN_BASE ||
                       host_addr_i >= WEN_BASE + ADDR_W'(NUM_FLASH)))
        |=> $stable(flash_wen_o));

endmodule

// File: tb/boot_flash_guard_test.sv
`timescale 1ns/1ps
module boot_flash_guard_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] sw_wp;
    logic       sw_pkg, sw_man_en, sw_man_sel, mc_sel;
    logic       wr;
    logic [7:0] addr, wdata;
    logic [7:0] rdata;
    logic [1:0] wen;
    logic       bsel;

    int vectors = 0;
    int errors  = 0;

    always #2.5 clk = ~clk;

    boot_flash_guard uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .sw_wp_i      (sw_wp),
        .sw_pkg_i     (sw_pkg),
        .sw_man_en_i  (sw_man_en),
        .sw_man_sel_i (sw_man_sel),
        .mc_sel_i     (mc_sel),
        .host_wr_i    (wr),
        .host_addr_i  (addr),
        .host_wdata_i (wdata),
        .host_rdata_o (rdata),
        .flash_wen_o  (wen),
        .boot_sel_o   (bsel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write strobe: raised at a falling edge, checked at the next falling edge.
    task automatic host_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [1:0] prev;
        logic [1:0] exp_wen;
        logic       exp_sel;
        logic [7:0] exp_rd;
        rst_n = 1'b0; sw_wp = 2'b00; sw_pkg = 0; sw_man_en = 0; sw_man_sel = 0; mc_sel = 0;
        wr = 0; addr = 8'h00; wdata = 8'h00;
        repeat (4) @(negedge clk);
        check("R2 reset wen", wen, 2'b00);
        check("R7 reset sel", bsel, 1'b0);

        // Switch capture during reset, then freeze on release.
        prev = 2'b00;
        for (int s = 0; s < 4; s++) begin
            sw_wp = s[1:0];
            @(negedge clk); @(negedge clk);
            check("R1 wen not yet", wen, prev);
            @(negedge clk);
            check("R2 wen follows switch", wen, s[1:0]);
            host_write(8'h41, 8'hC3);
            host_write(8'h42, 8'hC3);
            host_write(8'h41, 8'h00);
            check("R6 write in reset", wen, s[1:0]);
            rst_n = 1'b1;
            @(negedge clk);
            sw_wp = ~s[1:0];
            repeat (4) @(negedge clk);
            check("R2 frozen after release", wen, s[1:0]);
            rst_n = 1'b0;
            prev = ~s[1:0];
            repeat (3) @(negedge clk);
            prev = sw_wp;
        end
        sw_wp = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_wen = 2'b00;

        // Full data sweep on both permission registers.
        for (int f = 0; f < 2; f++) begin
            for (int d = 0; d < 256; d++) begin
                host_write(8'h41 + 8'(f), 8'hC3);
                exp_wen[f] = 1'b1;
                check(f == 0 ? "R3 unlock" : "R5 unlock", wen, exp_wen);
                host_write(8'h41 + 8'(f), 8'(d));
                exp_wen[f] = (d == 8'hC3);
                check(f == 0 ? "R4 data sweep" : "R5 data sweep", wen, exp_wen);
            end
        end

        // Writes to every other offset must not disturb permission.
        host_write(8'h41, 8'hC3);
        host_write(8'h42, 8'h5A);
        for (int a = 0; a < 256; a++) begin
            if (a != 8'h41 && a != 8'h42) begin
                host_write(8'(a), 8'hC3);
                check("R9 foreign key write", wen, 2'b01);
                host_write(8'(a), 8'h00);
                check("R9 foreign zero write", wen, 2'b01);
            end
        end

        // Select latency: old after one edge, new after two.
        @(negedge clk);
        mc_sel = 1'b1;
        @(negedge clk);
        check("R1 sel not yet", bsel, 1'b0);
        @(negedge clk);
        check("R1 sel arrives", bsel, 1'b1);
        mc_sel = 1'b0;
        @(negedge clk);
        check("R1 sel not yet fall", bsel, 1'b1);
        @(negedge clk);
        check("R1 sel falls", bsel, 1'b0);

        // Select mux and status read over every input combination and address.
        for (int v = 0; v < 16; v++) begin
            @(negedge clk);
            {mc_sel, sw_man_sel, sw_man_en, sw_pkg} = v[3:0];
            @(negedge clk); @(negedge clk);
            exp_sel = sw_man_en ? sw_man_sel : mc_sel;
            check("R7 boot select", bsel, exp_sel);
            for (int a = 0; a < 256; a++) begin
                addr = 8'(a);
                #1;
                exp_rd = (a == 8'h40) ? {mc_sel, sw_man_sel, sw_man_en, sw_pkg, 4'h0} : 8'h00;
                check("R8 read data", rdata, exp_rd);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule